// File: doc/BRIEF.md
# Reconfigurable Region Freeze Bridge

The block sits in the fabric between a host request/response channel and one reconfigurable region. It decides when that region may see host traffic. Software drives it through a small register window. A freeze request first stops new host requests and lets the requests already inside the region finish. Only then does the block report the region as frozen. While the region is frozen, host requests are answered locally with an error and never reach the region, and anything the region emits toward the host is dropped. The region reset output is asserted only on request, and only while the region is frozen. An unfreeze request reopens the path.

Requests that do not fit the current state are refused. A refused request changes neither the state nor the control register, and it sets a bit in a sticky illegal-request register that software clears explicitly. A fixed version register identifies the register layout.

Top module: `region_freeze_bridge`

## Requirements
- R1: After reset, status reads 2 (bit 1 "open" set, bit 0 "frozen" clear), control reads 0, illegal reads 0, and regionRst is low.
- R2: Byte offsets: status 0, control 4, illegal 8, version 12. Version always reads 2.
- R3: While open, host requests are forwarded unchanged to the region. Region responses return to the host in order with hostRspErr low.
- R4: At most MAX_OUT forwarded requests may be awaiting a response. With MAX_OUT outstanding, hostReqReady is low.
- R5: Writing control with bit 0 (freeze) set while open starts a drain:
  - hostReqReady goes low and status reads 0 while any request is outstanding.
  - Status becomes 1 (bit 0 set, bit 1 clear) one cycle after the outstanding count reaches zero.
- R6: While frozen, each host request is accepted and answered the next cycle with hostRspErr high and data 0. regReqValid stays low. A region response never reaches the host.
- R7: While frozen, a control value with bit 1 (reset) set drives regionRst high until the control register changes. Status stays 1.
- R8: Writing 0 to control clears all request bits and releases regionRst, with no change of the open, draining or frozen state.
- R9: A freeze while frozen, or an unfreeze (control bit 2) while open, changes nothing and raises no illegal bit.
- R10: Illegal control writes change neither the state nor the control register. Each one sets an illegal-register bit:
  - bit 0: freeze and unfreeze written together.
  - bit 1: freeze while draining.
  - bit 2: unfreeze while draining.
  - bit 3: reset request while not frozen.
- R11: Writing the illegal register with bit 0 set clears it to 0. A write with bit 0 clear has no effect. Bits stay set until cleared.
- R12: Unfreeze while frozen makes status read 2 on the next cycle, and forwarding resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Register write strobe |
| csrAddr | input | ADDR_W | Register byte offset |
| csrWrData | input | 32 | Register write data |
| csrRdData | output | 32 | Read data for csrAddr (combinational) |
| hostReqValid | input | 1 | Host request valid |
| hostReqReady | output | 1 | Host request accepted |
| hostReqData | input | DATA_W | Host request payload |
| hostRspValid | output | 1 | Response valid toward host |
| hostRspData | output | DATA_W | Response payload |
| hostRspErr | output | 1 | Response is a local error |
| regReqValid | output | 1 | Request valid toward region |
| regReqReady | input | 1 | Region accepts request |
| regReqData | output | DATA_W | Request payload toward region |
| regRspValid | input | 1 | Region response valid |
| regRspData | input | DATA_W | Region response payload |
| regionRst | output | 1 | Active-high region reset |

## Verification
The bench builds the block with DATA_W=16 and MAX_OUT=3. With that limit, three held responses are enough to close the request path and to keep a drain pending across several cycles while the status is read. The narrow payload lets random traffic hit all-zero and all-one words often.

// File: rtl/region_freeze_pkg.sv
package region_freeze_pkg;

  localparam int CSR_W = 32;
  localparam int CTRL_W = 3;
  localparam int ILL_W = 4;

  localparam int OFF_STATUS = 0;
  localparam int OFF_CTRL = 4;
  localparam int OFF_ILLEGAL = 8;
  localparam int OFF_VERSION = 12;
  localparam logic [CSR_W-1:0] LAYOUT_VERSION = 32'd2;

  localparam int CB_FREEZE = 0;
  localparam int CB_RESET = 1;
  localparam int CB_UNFREEZE = 2;

  localparam int IB_BOTH = 0;
  localparam int IB_FRZ_DRAIN = 1;
  localparam int IB_UNF_DRAIN = 2;
  localparam int IB_RST_OPEN = 3;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FROZEN = 2'd2
  } frzState_t;

  typedef struct packed {
    logic passEn;
    logic blockNew;
    logic localErr;
    logic regionRst;
  } gateCtl_t;

endpackage

// File: rtl/region_freeze_gate.sv
module region_freeze_gate
  import region_freeze_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_OUT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateCtl_t          gateCtl,
  output logic              drainIdle,
  input  logic              hostReqValid,
  output logic              hostReqReady,
  input  logic [DATA_W-1:0] hostReqData,
  output logic              hostRspValid,
  output logic [DATA_W-1:0] hostRspData,
  output logic              hostRspErr,
  output logic              regReqValid,
  input  logic              regReqReady,
  output logic [DATA_W-1:0] regReqData,
  input  logic              regRspValid,
  input  logic [DATA_W-1:0] regRspData
);

  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] cntQ;
  logic errPendQ;
  logic fwdOk;
  logic reqFire;
  logic rspPass;

  assign fwdOk = gateCtl.passEn && !errPendQ && (cntQ < CNT_MAX);
  assign regReqValid = hostReqValid && fwdOk;
  assign regReqData = hostReqData;
  assign reqFire = regReqValid && regReqReady;

  always_comb begin
    if (gateCtl.localErr) hostReqReady = 1'b1;
    else if (gateCtl.blockNew) hostReqReady = 1'b0;
    else hostReqReady = fwdOk && regReqReady;
  end

  assign rspPass = regRspValid && !gateCtl.localErr;
  assign hostRspValid = errPendQ || rspPass;
  assign hostRspData = errPendQ ? '0 : regRspData;
  assign hostRspErr = errPendQ;
  assign drainIdle = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      errPendQ <= 1'b0;
    end else begin
      errPendQ <= gateCtl.localErr && hostReqValid;
      if (reqFire && !(rspPass && cntQ != '0)) cntQ <= cntQ + 1'b1;
      else if (!reqFire && rspPass && cntQ != '0) cntQ <= cntQ - 1'b1;
    end
  end

  assert_frozen_no_forward_R6 : assert property (@(posedge clk) disable iff (!rstN)
    gateCtl.localErr |-> !regReqValid);

  assert_err_reply_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (gateCtl.localErr && hostReqValid) |=> (hostRspValid && hostRspErr));

  assert_cnt_bound_R4 : assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_MAX);

  assert_drain_stall_R5 : assert property (@(posedge clk) disable iff (!rstN)
    gateCtl.blockNew |-> !hostReqReady);

endmodule

// File: rtl/region_freeze_ctrl.sv
module region_freeze_ctrl
  import region_freeze_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [CSR_W-1:0]  csrWrData,
  output logic [CSR_W-1:0]  csrRdData,
  input  logic              drainIdle,
  output gateCtl_t          gateCtl
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_ILLEGAL = ADDR_W'(OFF_ILLEGAL);
  localparam logic [ADDR_W-1:0] A_VERSION = ADDR_W'(OFF_VERSION);

  frzState_t stateQ, stateD;
  logic [CTRL_W-1:0] ctrlQ;
  logic [ILL_W-1:0] illQ;
  logic [ILL_W-1:0] illHit;
  logic ctrlWr, ctrlOk, illClr;
  logic reqFrz, reqRst, reqUnf;
  logic unusedWrBits;

  assign unusedWrBits = ^csrWrData[CSR_W-1:CTRL_W];
  assign ctrlWr = csrWrEn && (csrAddr == A_CTRL);
  assign illClr = csrWrEn && (csrAddr == A_ILLEGAL) && csrWrData[0];
  assign reqFrz = csrWrData[CB_FREEZE];
  assign reqRst = csrWrData[CB_RESET];
  assign reqUnf = csrWrData[CB_UNFREEZE];

  always_comb begin
    illHit = '0;
    if (ctrlWr) begin
      if (reqFrz && reqUnf) begin
        illHit[IB_BOTH] = 1'b1;
      end else begin
        if (reqFrz && stateQ == ST_DRAIN) illHit[IB_FRZ_DRAIN] = 1'b1;
        if (reqUnf && stateQ == ST_DRAIN) illHit[IB_UNF_DRAIN] = 1'b1;
        if (reqRst && stateQ != ST_FROZEN) illHit[IB_RST_OPEN] = 1'b1;
      end
    end
    ctrlOk = ctrlWr && (illHit == '0);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_OPEN: if (ctrlOk && reqFrz) stateD = ST_DRAIN;
      ST_DRAIN: if (drainIdle) stateD = ST_FROZEN;
      ST_FROZEN: if (ctrlOk && reqUnf) stateD = ST_OPEN;
      default: stateD = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_OPEN;
      ctrlQ <= '0;
      illQ <= '0;
    end else begin
      stateQ <= stateD;
      if (ctrlOk) ctrlQ <= csrWrData[CTRL_W-1:0];
      if (illClr) illQ <= '0;
      else illQ <= illQ | illHit;
    end
  end

  always_comb begin
    gateCtl.passEn = (stateQ == ST_OPEN);
    gateCtl.blockNew = (stateQ == ST_DRAIN);
    gateCtl.localErr = (stateQ == ST_FROZEN);
    gateCtl.regionRst = (stateQ == ST_FROZEN) && ctrlQ[CB_RESET];
  end

  always_comb begin
    csrRdData = '0;
    unique case (csrAddr)
      A_STATUS: csrRdData[1:0] = {stateQ == ST_OPEN, stateQ == ST_FROZEN};
      A_CTRL: csrRdData[CTRL_W-1:0] = ctrlQ;
      A_ILLEGAL: csrRdData[ILL_W-1:0] = illQ;
      A_VERSION: csrRdData = LAYOUT_VERSION;
      default: csrRdData = '0;
    endcase
  end

  assert_drain_waits_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DRAIN && !drainIdle) |=> (stateQ == ST_DRAIN));

  assert_refused_keeps_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && illHit != '0 && stateQ != ST_DRAIN) |=> ($stable(stateQ) && $stable(ctrlQ)));

  assert_ill_sticky_R11 : assert property (@(posedge clk) disable iff (!rstN)
    (illQ != '0 && !illClr) |=> (illQ != '0));

  assert_clear_keeps_state_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && csrWrData[CTRL_W-1:0] == '0 && stateQ != ST_DRAIN) |=> $stable(stateQ));

endmodule

// File: rtl/region_freeze_bridge.sv
module region_freeze_bridge
  import region_freeze_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_OUT = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [31:0]       csrWrData,
  output logic [31:0]       csrRdData,
  input  logic              hostReqValid,
  output logic              hostReqReady,
  input  logic [DATA_W-1:0] hostReqData,
  output logic              hostRspValid,
  output logic [DATA_W-1:0] hostRspData,
  output logic              hostRspErr,
  output logic              regReqValid,
  input  logic              regReqReady,
  output logic [DATA_W-1:0] regReqData,
  input  logic              regRspValid,
  input  logic [DATA_W-1:0] regRspData,
  output logic              regionRst
);

  gateCtl_t gateCtl;
  logic drainIdle;

  region_freeze_ctrl #(.ADDR_W(ADDR_W)) ctrlUnit (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrAddr(csrAddr),
    .csrWrData(csrWrData), .csrRdData(csrRdData),
    .drainIdle(drainIdle), .gateCtl(gateCtl)
  );

  region_freeze_gate #(.DATA_W(DATA_W), .MAX_OUT(MAX_OUT)) gateUnit (
    .clk(clk), .rstN(rstN), .gateCtl(gateCtl), .drainIdle(drainIdle),
    .hostReqValid(hostReqValid), .hostReqReady(hostReqReady), .hostReqData(hostReqData),
    .hostRspValid(hostRspValid), .hostRspData(hostRspData), .hostRspErr(hostRspErr),
    .regReqValid(regReqValid), .regReqReady(regReqReady), .regReqData(regReqData),
    .regRspValid(regRspValid), .regRspData(regRspData)
  );

  assign regionRst = gateCtl.regionRst;

endmodule

// File: tb/region_freeze_bridge_test.sv
`timescale 1ns/1ps
module region_freeze_bridge_test;
  localparam int DW = 16;
  localparam int MO = 3;
  localparam int AW = 4;

  logic clk = 0, rstN = 0;
  logic csrWrEn = 0;
  logic [AW-1:0] csrAddr = '0;
  logic [31:0] csrWrData = '0, csrRdData;
  logic hostReqValid = 0, hostReqReady;
  logic [DW-1:0] hostReqData = '0;
  logic hostRspValid, hostRspErr;
  logic [DW-1:0] hostRspData;
  logic regReqValid, regReqReady = 0;
  logic [DW-1:0] regReqData;
  logic regRspValid = 0;
  logic [DW-1:0] regRspData = '0;
  logic regionRst;

  int errors = 0, checks = 0;
  bit done = 0;
  bit rspEn = 1, readyForce = 1, expectFrozen = 0, injectRsp = 0;
  logic [DW:0] expQ[$];
  logic [DW-1:0] regQ[$];
  logic [31:0] rd;

  always #4 clk = ~clk;

  region_freeze_bridge #(.DATA_W(DW), .MAX_OUT(MO), .ADDR_W(AW)) uut (.*);

  function automatic logic [DW-1:0] rspOf(input logic [DW-1:0] d);
    return d ^ 16'hA5C3;
  endfunction

  function automatic logic [31:0] expStatus(input bit frozen);
    return frozen ? 32'd1 : 32'd2;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // region model and response monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      regReqReady = readyForce || ($urandom_range(0, 3) != 0);
      if (injectRsp) begin
        regRspValid = 1; regRspData = 16'hBEEF;
      end else if (rspEn && regQ.size() > 0) begin
        regRspValid = 1; regRspData = regQ[0];
      end else begin
        regRspValid = 0;
      end
      #2;
      if (rstN) begin
        if (hostReqValid && hostReqReady)
          expQ.push_back(expectFrozen ? {1'b1, {DW{1'b0}}} : {1'b0, rspOf(hostReqData)});
        if (regReqValid && regReqReady) regQ.push_back(rspOf(regReqData));
        if (regRspValid && !injectRsp) void'(regQ.pop_front());
        if (hostRspValid) begin
          if (expQ.size() == 0) chk("R3 unexpected response", 1, 0);
          else begin
            logic [DW:0] e;
            e = expQ.pop_front();
            chk(e[DW] ? "R6 error reply" : "R3 pass data", {hostRspErr, hostRspData}, e);
          end
        end
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csrWr(input int a, input logic [31:0] d);
    @(negedge clk); csrWrEn = 1; csrAddr = AW'(a); csrWrData = d;
    @(negedge clk); csrWrEn = 0;
  endtask

  task automatic csrRd(input int a, output logic [31:0] d);
    @(negedge clk); csrAddr = AW'(a);
    #3; d = csrRdData;
  endtask

  task automatic hostSend(input logic [DW-1:0] d);
    @(negedge clk); hostReqValid = 1; hostReqData = d;
    #3;
    while (!hostReqReady) begin @(negedge clk); #3; end
    @(negedge clk); hostReqValid = 0;
  endtask

  initial begin
    cycles(200000);
    chk("watchdog", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd9157));
    cycles(4);
    rstN = 1;
    // R1 reset state
    csrRd(0, rd); chk("R1 status", rd, expStatus(0));
    csrRd(4, rd); chk("R1 ctrl", rd, 0);
    csrRd(8, rd); chk("R1 illegal", rd, 0);
    chk("R1 regionRst", regionRst, 0);
    csrRd(12, rd); chk("R2 version", rd, 2);

    // R3 directed pass-through
    foreach (expQ[i]) ;
    hostSend(16'h0000); hostSend(16'hFFFF); hostSend(16'h1234);
    hostSend(16'h8001); hostSend(16'h5A5A);
    cycles(8);
    chk("R3 all responses", expQ.size(), 0);

    // R4 outstanding limit
    rspEn = 0;
    for (int i = 0; i < MO; i++) hostSend(DW'(16'h0100 + i));
    @(negedge clk); hostReqValid = 1; hostReqData = 16'h0F0F;
    #3; chk("R4 ready low at limit", hostReqReady, 0);
    @(negedge clk); hostReqValid = 0;

    // R5 drain then freeze
    csrWr(4, 32'd1);
    csrRd(0, rd); chk("R5 status while draining", rd, 0);
    chk("R5 host stalled", hostReqReady, 0);
    cycles(2);
    csrRd(0, rd); chk("R5 still draining", rd, 0);
    rspEn = 1;
    cycles(6);
    csrRd(0, rd); chk("R5 status frozen", rd, expStatus(1));
    chk("R5 drained", expQ.size(), 0);

    // R6 frozen behaviour
    expectFrozen = 1;
    @(negedge clk); hostReqValid = 1; hostReqData = 16'h7777;
    #3; chk("R6 no forward", regReqValid, 0); chk("R6 accepted", hostReqReady, 1);
    @(negedge clk); hostReqValid = 0;
    cycles(3);
    injectRsp = 1;
    @(negedge clk); #3; chk("R6 region response dropped", hostRspValid, 0);
    @(negedge clk); #3; chk("R6 region response dropped", hostRspValid, 0);
    injectRsp = 0;
    cycles(2);
    chk("R6 error reply seen", expQ.size(), 0);

    // R7 reset request
    csrWr(4, 32'd2);
    #3; chk("R7 regionRst high", regionRst, 1);
    csrRd(0, rd); chk("R7 status frozen", rd, expStatus(1));
    // R8 clear control
    csrWr(4, 32'd0);
    #3; chk("R8 regionRst released", regionRst, 0);
    csrRd(0, rd); chk("R8 state kept", rd, expStatus(1));
    csrRd(4, rd); chk("R8 ctrl cleared", rd, 0);

    // R9 freeze while frozen
    csrWr(4, 32'd1);
    csrRd(8, rd); chk("R9 no illegal", rd, 0);
    csrRd(0, rd); chk("R9 still frozen", rd, expStatus(1));

    // R10 both bits
    csrWr(4, 32'd5);
    csrRd(8, rd); chk("R10 both bits flag", rd, 1);
    csrRd(0, rd); chk("R10 state kept", rd, expStatus(1));
    csrRd(4, rd); chk("R10 ctrl kept", rd, 1);

    // R11 clear semantics
    csrWr(8, 32'd2);
    csrRd(8, rd); chk("R11 write without bit0 ignored", rd, 1);
    csrWr(8, 32'd1);
    csrRd(8, rd); chk("R11 cleared", rd, 0);

    // R12 unfreeze
    csrWr(4, 32'd4);
    csrRd(0, rd); chk("R12 open again", rd, expStatus(0));
    expectFrozen = 0;
    hostSend(16'hC0DE);
    cycles(4);
    chk("R12 forwarding resumed", expQ.size(), 0);

    // R9 unfreeze while open
    csrWr(4, 32'd4);
    csrRd(8, rd); chk("R9 unfreeze no-op", rd, 0);
    csrRd(0, rd); chk("R9 still open", rd, expStatus(0));

    // R10 reset while open
    csrWr(4, 32'd2);
    csrRd(8, rd); chk("R10 reset while open", rd, 8);
    chk("R10 no region reset", regionRst, 0);
    csrWr(8, 32'd1);

    // R10 requests during drain
    rspEn = 0;
    hostSend(16'h4242);
    csrWr(4, 32'd1);
    csrWr(4, 32'd4);
    csrRd(8, rd); chk("R10 unfreeze while draining", rd, 4);
    csrWr(4, 32'd1);
    csrRd(8, rd); chk("R10 freeze while draining", rd, 6);
    csrRd(0, rd); chk("R10 drain unaffected", rd, 0);
    rspEn = 1;
    cycles(6);
    csrRd(0, rd); chk("R5 frozen after drain", rd, expStatus(1));
    csrWr(8, 32'd1);
    csrWr(4, 32'd4);
    csrRd(0, rd); chk("R12 reopened", rd, expStatus(0));

    // random traffic
    readyForce = 0;
    for (int i = 0; i < 300; i++) begin
      hostSend(DW'($urandom));
      if ($urandom_range(0, 3) == 0) cycles($urandom_range(1, 3));
    end
    cycles(20);
    chk("R3 random all answered", expQ.size(), 0);
    chk("R3 region queue empty", regQ.size(), 0);
    finishRun();
  end
endmodule